// File: doc/BRIEF.md
# Local-Bus to Dual-Port SRAM Sequencer

This block is a synchronous controller placed between the non-multiplexed local bus of a PCI target bridge and one port of an asynchronous 16-bit dual-port static RAM. The bus master starts each 16-bit transfer with an address strobe, a direction line and two chip selects. The controller then runs a fixed multi-cycle sequence. The sequence drives the RAM chip enables, read/write, byte enables, output enable, address and data. When the data phase is reached, the controller returns a single-clock ready strobe to the master.

The local bus runs in single-cycle mode, so a 32-bit host access reaches the controller as two independent 16-bit transfers, each opened by its own strobe. A settling cycle sits inside every sequence. The RAM strobes are withdrawn in stages, and a guaranteed idle cycle separates consecutive transfers. A few static bus-configuration outputs are held at fixed levels: burst terminate high, mode select high, hold request low and bus mode low.

Top module: `lbus_dpram_seq`

## Requirements
- R1: While reset is asserted and right after it, all active-low RAM strobes (`ram_ce_n`=2'b11, `ram_sem_n`, `ram_rw_n`, `ram_ub_n`, `ram_lb_n`, `ram_oe_n`) are 1, `ram_dq_oe` and `ld_oe` are 0, `lrdy_n` is 1, `term_n` and `msel` are 1, and `hold_req` and `bmode` are 0.
- R2: A write starts only when the idle controller samples, on a rising edge, `ads_n`=0, `wr_rd`=1 and `cs_n`≠2'b11. With `cs_n`=2'b11 nothing happens.
- R3: A read starts only when the idle controller samples `ads_n`=0, `wr_rd`=0 and `cs_n`≠2'b11.
- R4: Number the rising edges from the one that samples the strobe (edge 0). After edge 1, the RAM address, byte enables (`ram_ub_n`=`lbe_n[1]`, `ram_lb_n`=`lbe_n[0]`) and chip enables are driven, with `ram_rw_n`=0 for a write and 1 for a read. All are values latched at edge 0. They do not change at edge 2.
- R5: Chip-enable decode: `ram_ce_n[i]` goes low exactly when `cs_n[i]` was low at edge 0. `ram_sem_n` stays 1 for every data transfer.
- R6: On a write, after edge 3 `ram_dq_oe`=1 and `ram_dq_out` carries `ld_in` as sampled at edge 3. It keeps that value until the bus is released.
- R7: On a write, after edge 4 the chip enables return to 1 while `ram_rw_n`, the byte enables and `ram_dq_oe` remain active. After edge 5 these are released as well.
- R8: On a read, `ram_oe_n` goes to 0 after edge 1 together with the chip enables. After edge 3 `ld_oe`=1 and `ld_out` carries `ram_dq_in` as sampled at edge 3.
- R9: On a read, the chip enables, output enable, byte enables and `ld_oe` all stay active through edge 4 and are released together after edge 5.
- R10: `lrdy_n` is 0 for exactly one clock, after edge 3 of every transfer.
- R11: `ads_n` is ignored while a transfer runs. A strobe held low continuously starts the next transfer no earlier than edge 6, which leaves at least one idle cycle after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ads_n | input | 1 | Address strobe, active low |
| wr_rd | input | 1 | Direction: 1 write, 0 read |
| cs_n | input | 2 | Chip selects, active low |
| la | input | ADDR_W | Local word address |
| lbe_n | input | 2 | Byte enables, active low (bit 1 upper) |
| ld_in | input | DATA_W | Write data from master |
| ld_out | output | DATA_W | Read data to master |
| ld_oe | output | 1 | Drive enable for `ld_out` |
| lrdy_n | output | 1 | Ready strobe, active low |
| term_n | output | 1 | Burst terminate, held high |
| msel | output | 1 | Mode select, held high |
| hold_req | output | 1 | Hold request, held low |
| bmode | output | 1 | Bus mode, held low |
| ram_ce_n | output | 2 | RAM chip enables, active low |
| ram_sem_n | output | 1 | RAM semaphore enable, active low |
| ram_rw_n | output | 1 | RAM read/write (0 write) |
| ram_ub_n | output | 1 | RAM upper byte enable |
| ram_lb_n | output | 1 | RAM lower byte enable |
| ram_oe_n | output | 1 | RAM output enable |
| ram_addr | output | ADDR_W | RAM address |
| ram_dq_out | output | DATA_W | Data driven to RAM |
| ram_dq_oe | output | 1 | Drive enable for `ram_dq_out` |
| ram_dq_in | input | DATA_W | Data returned by RAM |

## Verification
The assertions assume that the master holds `ld_in` valid through edge 3 of a write. They also assume that the RAM presents stable read data by edge 3, two clocks after its strobes were applied. The assertions never look at the strobe timing itself, because the controller ignores `ads_n` once busy. The stimulus changes all inputs only on falling edges. It keeps `ld_in` and `ram_dq_in` stable across the sampling edge and then scrambles them once that edge has passed, so any late capture shows up. Address and byte enables are also scrambled right after edge 0, which checks that they were latched.

// File: rtl/lbus_dpram_seq.sv
module lbus_dpram_seq #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ads_n,
  input  logic              wr_rd,
  input  logic [1:0]        cs_n,
  input  logic [ADDR_W-1:0] la,
  input  logic [1:0]        lbe_n,
  input  logic [DATA_W-1:0] ld_in,
  output logic [DATA_W-1:0] ld_out,
  output logic              ld_oe,
  output logic              lrdy_n,
  output logic              term_n,
  output logic              msel,
  output logic              hold_req,
  output logic              bmode,
  output logic [1:0]        ram_ce_n,
  output logic              ram_sem_n,
  output logic              ram_rw_n,
  output logic              ram_ub_n,
  output logic              ram_lb_n,
  output logic              ram_oe_n,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_dq_out,
  output logic              ram_dq_oe,
  input  logic [DATA_W-1:0] ram_dq_in
);

  typedef enum logic [3:0] {
    IDLE, W_GO, W_SET, W_HOLD, W_DATA, W_DONE,
    R_GO, R_SET, R_HOLD, R_DATA, R_DONE
  } seq_t;

  seq_t state, nx;
  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        sel_q, be_q;

  assign term_n    = 1'b1;
  assign msel      = 1'b1;
  assign hold_req  = 1'b0;
  assign bmode     = 1'b0;
  assign ram_sem_n = 1'b1;

  wire begin_x = !ads_n && (cs_n != 2'b11);

  always_comb begin
    nx = state;
    case (state)
      IDLE:    if (begin_x) nx = wr_rd ? W_GO : R_GO;
      W_GO:    nx = W_SET;
      W_SET:   nx = W_HOLD;
      W_HOLD:  nx = W_DATA;
      W_DATA:  nx = W_DONE;
      W_DONE:  nx = IDLE;
      R_GO:    nx = R_SET;
      R_SET:   nx = R_HOLD;
      R_HOLD:  nx = R_DATA;
      R_DATA:  nx = R_DONE;
      R_DONE:  nx = IDLE;
      default: nx = IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= IDLE;
      addr_q     <= '0;
      sel_q      <= 2'b11;
      be_q       <= 2'b11;
      ld_out     <= '0;
      ld_oe      <= 1'b0;
      lrdy_n     <= 1'b1;
      ram_ce_n   <= 2'b11;
      ram_rw_n   <= 1'b1;
      ram_ub_n   <= 1'b1;
      ram_lb_n   <= 1'b1;
      ram_oe_n   <= 1'b1;
      ram_addr   <= '0;
      ram_dq_out <= '0;
      ram_dq_oe  <= 1'b0;
    end else begin
      state <= nx;
      if (state == IDLE && nx != IDLE) begin
        addr_q <= la;
        sel_q  <= cs_n;
        be_q   <= lbe_n;
      end
      case (nx)
        W_SET, R_SET: begin
          ram_ce_n <= sel_q;
          ram_rw_n <= (nx == R_SET);
          ram_oe_n <= (nx != R_SET);
          ram_ub_n <= be_q[1];
          ram_lb_n <= be_q[0];
          ram_addr <= addr_q;
        end
        W_DATA: begin
          lrdy_n     <= 1'b0;
          ram_dq_oe  <= 1'b1;
          ram_dq_out <= ld_in;
        end
        R_DATA: begin
          lrdy_n <= 1'b0;
          ld_oe  <= 1'b1;
          ld_out <= ram_dq_in;
        end
        W_DONE: begin
          lrdy_n   <= 1'b1;
          ram_ce_n <= 2'b11;
        end
        R_DONE: lrdy_n <= 1'b1;
        IDLE: if (state != IDLE) begin
          ram_ce_n  <= 2'b11;
          ram_rw_n  <= 1'b1;
          ram_ub_n  <= 1'b1;
          ram_lb_n  <= 1'b1;
          ram_oe_n  <= 1'b1;
          ram_dq_oe <= 1'b0;
          ld_oe     <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  // R10
  rdy_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lrdy_n |=> lrdy_n);

  // R10
  rdy_needs_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lrdy_n |-> (ram_ce_n != 2'b11));

  // R6
  dq_only_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_dq_oe |-> !ram_rw_n);

  // R8
  oe_only_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_oe_n |-> (ram_rw_n && !ld_oe |-> ram_ce_n != 2'b11));

  // R7
  wr_staged_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_rw_n && ram_ce_n == 2'b11 && $past(ram_ce_n) != 2'b11)
    |=> (ram_rw_n && ram_ub_n && ram_lb_n && !ram_dq_oe));

  // R9
  rd_joint_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!ram_oe_n) && ram_oe_n) |-> (ram_ce_n == 2'b11 && !ld_oe));

  // R11
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == W_DONE || state == R_DONE) |=> (state == IDLE));

  // R5
  sem_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_ce_n != 2'b11) |-> ram_sem_n);

endmodule

// File: tb/lbus_dpram_seq_tb_top.sv
module lbus_dpram_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ads_n = 1'b1, wr_rd = 1'b0;
  logic [1:0]  cs_n = 2'b11, lbe_n = 2'b11;
  logic [15:0] la = '0, ld_in = '0, ram_dq_in = '0;
  logic [15:0] ld_out, ram_addr, ram_dq_out;
  logic        ld_oe, lrdy_n, term_n, msel, hold_req, bmode;
  logic [1:0]  ram_ce_n;
  logic        ram_sem_n, ram_rw_n, ram_ub_n, ram_lb_n, ram_oe_n, ram_dq_oe;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  lbus_dpram_seq dut_i (
    .clk(clk), .rst_n(rst_n), .ads_n(ads_n), .wr_rd(wr_rd), .cs_n(cs_n),
    .la(la), .lbe_n(lbe_n), .ld_in(ld_in), .ld_out(ld_out), .ld_oe(ld_oe),
    .lrdy_n(lrdy_n), .term_n(term_n), .msel(msel), .hold_req(hold_req),
    .bmode(bmode), .ram_ce_n(ram_ce_n), .ram_sem_n(ram_sem_n),
    .ram_rw_n(ram_rw_n), .ram_ub_n(ram_ub_n), .ram_lb_n(ram_lb_n),
    .ram_oe_n(ram_oe_n), .ram_addr(ram_addr), .ram_dq_out(ram_dq_out),
    .ram_dq_oe(ram_dq_oe), .ram_dq_in(ram_dq_in));

  // {we, cs_n[1:0], addr[15:0], be_n[1:0], wdata[15:0], rdata[15:0]}
  localparam logic [52:0] VEC [8] = '{
    {1'b1, 2'b10, 16'h0001, 2'b00, 16'hA5A5, 16'h0000},
    {1'b1, 2'b01, 16'hFFFE, 2'b01, 16'h1234, 16'h0000},
    {1'b0, 2'b10, 16'h8000, 2'b00, 16'h0000, 16'hBEEF},
    {1'b0, 2'b01, 16'h00FF, 2'b10, 16'h0000, 16'h5A5A},
    {1'b1, 2'b00, 16'h7777, 2'b10, 16'hFFFF, 16'h0000},
    {1'b0, 2'b00, 16'h0000, 2'b01, 16'h0000, 16'hFFFF},
    {1'b1, 2'b10, 16'hC3C3, 2'b11, 16'h0000, 16'h0000},
    {1'b0, 2'b01, 16'h3C3C, 2'b00, 16'h0000, 16'h0001}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_released(input string req);
    chk({req, " ce"}, 32'(ram_ce_n), 32'h3);
    chk({req, " rw/ub/lb/oe"}, {28'd0, ram_rw_n, ram_ub_n, ram_lb_n, ram_oe_n}, 32'hF);
    chk({req, " drive"}, {30'd0, ram_dq_oe, ld_oe}, 32'h0);
    chk({req, " rdy"}, 32'(lrdy_n), 32'h1);
    chk({req, " sem"}, 32'(ram_sem_n), 32'h1);
  endtask

  task automatic run_xfer(input logic [52:0] v);
    logic we; logic [1:0] cs, be; logic [15:0] ad, wd, rd;
    {we, cs, ad, be, wd, rd} = v;
    @(negedge clk);
    ads_n = 1'b0; wr_rd = we; cs_n = cs; la = ad; lbe_n = be;
    ld_in = wd; ram_dq_in = rd;
    @(negedge clk); // after edge 0
    ads_n = 1'b1; cs_n = 2'b11; la = ~ad; lbe_n = ~be; wr_rd = ~we;
    chk("R4 idle at e0", 32'(ram_ce_n), 32'h3);
    @(negedge clk); // after edge 1
    chk("R5 ce decode", 32'(ram_ce_n), 32'(cs));
    chk("R4 rw", 32'(ram_rw_n), 32'(!we));
    chk("R4 addr", 32'(ram_addr), 32'(ad));
    chk("R4 ub/lb", {30'd0, ram_ub_n, ram_lb_n}, 32'(be));
    chk(we ? "R8 oe off on write" : "R8 oe on", 32'(ram_oe_n), 32'(we));
    chk("R10 rdy early", 32'(lrdy_n), 32'h1);
    @(negedge clk); // after edge 2
    chk("R4 hold", {ram_ce_n, ram_rw_n, ram_ub_n, ram_lb_n, ram_oe_n, ram_addr, 10'd0},
        {cs, !we, be, we, ad, 10'd0});
    chk("R10 rdy early", 32'(lrdy_n), 32'h1);
    @(negedge clk); // after edge 3
    ld_in = ~wd; ram_dq_in = ~rd;
    chk("R10 rdy", 32'(lrdy_n), 32'h0);
    if (we) begin
      chk("R6 dq_oe", 32'(ram_dq_oe), 32'h1);
      chk("R6 dq data", 32'(ram_dq_out), 32'(wd));
    end else begin
      chk("R8 ld_oe", 32'(ld_oe), 32'h1);
      chk("R8 ld data", 32'(ld_out), 32'(rd));
    end
    @(negedge clk); // after edge 4
    chk("R10 rdy one clock", 32'(lrdy_n), 32'h1);
    if (we) begin
      chk("R7 ce off first", 32'(ram_ce_n), 32'h3);
      chk("R7 ctl kept", {29'd0, ram_rw_n, ram_dq_oe, ram_ub_n}, {29'd0, 1'b0, 1'b1, be[1]});
      chk("R6 data kept", 32'(ram_dq_out), 32'(wd));
    end else begin
      chk("R9 ce kept", 32'(ram_ce_n), 32'(cs));
      chk("R9 oe/ld_oe kept", {30'd0, ram_oe_n, ld_oe}, 32'h1);
      chk("R8 data kept", 32'(ld_out), 32'(rd));
    end
    @(negedge clk); // after edge 5
    chk_released(we ? "R7 release" : "R9 release");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk_released("R1 in reset");
    chk("R1 static", {28'd0, term_n, msel, hold_req, bmode}, 32'hC);
    rst_n = 1'b1;
    @(negedge clk);
    chk_released("R1 after reset");
    chk("R1 static", {28'd0, term_n, msel, hold_req, bmode}, 32'hC);

    for (int i = 0; i < 8; i++) run_xfer(VEC[i]);

    // R2 R3: strobe without chip select
    for (int d = 0; d < 2; d++) begin
      @(negedge clk);
      ads_n = 1'b0; cs_n = 2'b11; wr_rd = d[0];
      repeat (4) begin
        @(negedge clk);
        chk(d ? "R2 no cs no write" : "R3 no cs no read",
            {30'd0, ram_ce_n}, 32'h3);
        chk("R2 R3 no rdy", 32'(lrdy_n), 32'h1);
      end
      ads_n = 1'b1;
    end

    // R11: strobe held low across a whole transfer
    @(negedge clk);
    ads_n = 1'b0; wr_rd = 1'b1; cs_n = 2'b10; la = 16'h0042; lbe_n = 2'b00; ld_in = 16'h6666;
    repeat (4) @(negedge clk); // after edge 3
    chk("R11 rdy", 32'(lrdy_n), 32'h0);
    @(negedge clk); // after edge 4
    chk("R11 no restart", 32'(lrdy_n), 32'h1);
    @(negedge clk); // after edge 5
    chk_released("R11 released");
    @(negedge clk); // after edge 6: new start sampled
    chk("R11 dead cycle", 32'(ram_ce_n), 32'h3);
    @(negedge clk); // after edge 7
    chk("R11 second start", 32'(ram_ce_n), 32'h2);
    ads_n = 1'b1;
    repeat (6) @(negedge clk);
    chk_released("R11 final idle");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule